// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor core that finishes one instruction on every rising clock edge. The instruction is fetched from an internal instruction store at the program counter. It is decoded, and its register operands are read. The ALU computes a result, data memory is read or written, and the result is written back to the register file, all in the same cycle. The core supports eight operations: register-register add, subtract, AND, OR and signed set-on-less-than, plus word load, word store and branch-if-equal.

A shared load port fills the instruction store, or preloads the data store, before the program starts. Two observation ports show the current program counter and the contents of any register, so a test environment can follow the architectural state. The core is split into a decoder, which turns the opcode and function field into a packed set of control strobes, and a datapath that acts on those strobes.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0. No instruction writes a register or data memory while `rst` is high.
- R2: For opcode 0x00 (bits [31:26]), the function field (bits [5:0]) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. The 32-bit result of rs (bits [25:21]) with rt (bits [20:16]) is written to rd (bits [15:11]).
- R3: Opcode 0x00 with function 0x2A writes 1 to rd when rs is less than rt as signed two's-complement numbers, and writes 0 otherwise.
- R4: Opcode 0x23 (load) writes to rt the data word at byte address rs + sign-extended bits [15:0]. Negative offsets are allowed, and the word index is address bits [7:2].
- R5: Opcode 0x2B (store) writes rt into the data word at byte address rs + sign-extended bits [15:0], and writes no register.
- R6: Opcode 0x04 (branch) compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by two. Otherwise the next PC is PC+4. A branch writes no register or memory.
- R7: Every instruction that is not a taken branch advances the PC by exactly 4 at each rising edge out of reset.
- R8: Register 0 always reads as zero. A write aimed at it has no effect.
- R9: Any opcode other than 0x00, 0x23, 0x2B and 0x04 writes no register and no memory. So does opcode 0x00 with a function value not listed in R2 or R3.
- R10: With `loadEn` high at a rising edge, `loadData` is written to the word `loadAddr`. The word goes to the instruction store when `loadSel` is 0 and to the data store when `loadSel` is 1.
- R11: `dbgRegData` shows the current contents of register `dbgRegSel` combinationally, and `pcOut` shows the current PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Write strobe of the preload port |
| loadSel | input | 1 | Preload target: 0 instruction store, 1 data store |
| loadAddr | input | 8 | Word index for the preload port |
| loadData | input | 32 | Word written by the preload port |
| dbgRegSel | input | 5 | Register number to observe |
| dbgRegData | output | 32 | Contents of the observed register |
| pcOut | output | 32 | Current program counter |

## Verification
The bound checker watches the PC on every cycle. It confirms the reset value and the plus-four step of every non-branching instruction, and it recomputes each taken-branch target from the previous instruction word. It also confirms that stores, branches and unknown opcodes never raise a register write. Data results cannot be seen in the control strobes: add, subtract and logic values, signed comparison, the store-then-load round trip, negative offsets and the silence of register 0 appear only when the bench's program runs. The bench compares them against its behavioural model and against hand-computed final register values.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  // first-level class handed from the opcode decode to the ALU decode
  typedef enum logic [1:0] {
    CLS_MEM  = 2'b00,
    CLS_CMP  = 2'b01,
    CLS_REG  = 2'b10,
    CLS_NONE = 2'b11
  } op_cls_e;

  typedef struct packed {
    logic    destRd;     // 1: write rd, 0: write rt
    logic    regWrite;
    logic    useImm;     // second operand is sign-extended immediate
    logic    memRead;
    logic    memWrite;
    logic    wbFromMem;  // write-back data from data memory
    logic    isBranch;
    alu_op_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  op_cls_e    cls,
  input  logic [5:0] funct,
  output alu_op_e    aluOp,
  output logic       opKnown
);

  always_comb begin
    aluOp   = ALU_ADD;
    opKnown = 1'b0;
    unique case (cls)
      CLS_MEM: begin aluOp = ALU_ADD; opKnown = 1'b1; end
      CLS_CMP: begin aluOp = ALU_SUB; opKnown = 1'b1; end
      CLS_REG: begin
        opKnown = 1'b1;
        case (funct)
          FN_ADD:  aluOp = ALU_ADD;
          FN_SUB:  aluOp = ALU_SUB;
          FN_AND:  aluOp = ALU_AND;
          FN_OR:   aluOp = ALU_OR;
          FN_SLT:  aluOp = ALU_SLT;
          default: begin aluOp = ALU_ADD; opKnown = 1'b0; end
        endcase
      end
      default: begin aluOp = ALU_ADD; opKnown = 1'b0; end
    endcase
  end

endmodule

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic        rst,
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);

  logic [5:0] opcode;
  logic [5:0] funct;
  op_cls_e    cls;
  alu_op_e    aluOp;
  logic       opKnown;
  logic       isReg, isLoad, isStore, isBeq;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  assign isReg   = (opcode == OP_REG);
  assign isLoad  = (opcode == OP_LOAD);
  assign isStore = (opcode == OP_STORE);
  assign isBeq   = (opcode == OP_BEQ);

  always_comb begin
    if (isLoad || isStore) cls = CLS_MEM;
    else if (isBeq)        cls = CLS_CMP;
    else if (isReg)        cls = CLS_REG;
    else                   cls = CLS_NONE;
  end

  sc_alu_dec u_aluDec (
    .cls     (cls),
    .funct   (funct),
    .aluOp   (aluOp),
    .opKnown (opKnown)
  );

  always_comb begin
    ctrl           = '0;
    ctrl.aluOp     = aluOp;
    ctrl.destRd    = isReg;
    ctrl.useImm    = isLoad || isStore;
    ctrl.memRead   = isLoad;
    ctrl.wbFromMem = isLoad;
    ctrl.isBranch  = isBeq && !rst;
    ctrl.regWrite  = ((isReg && opKnown) || isLoad) && !rst;
    ctrl.memWrite  = isStore && !rst;
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RAW-1:0]  wAddr,
  input  logic [XLEN-1:0] wData,
  input  logic [RAW-1:0]  rAddrA,
  input  logic [RAW-1:0]  rAddrB,
  input  logic [RAW-1:0]  rAddrDbg,
  output logic [XLEN-1:0] rDataA,
  output logic [XLEN-1:0] rDataB,
  output logic [XLEN-1:0] rDataDbg
);

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (wAddr != '0)) begin
      regs[wAddr] <= wData;
    end
  end

  assign rDataA   = (rAddrA   == '0) ? '0 : regs[rAddrA];
  assign rDataB   = (rAddrB   == '0) ? '0 : regs[rAddrB];
  assign rDataDbg = (rAddrDbg == '0) ? '0 : regs[rAddrDbg];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = 8,
  localparam int IAW       = $clog2(IMEM_WORDS),
  localparam int DAW       = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  input  logic               loadEn,
  input  logic               loadSel,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [XLEN-1:0]    loadData,
  input  logic [4:0]         dbgRegSel,
  output logic [XLEN-1:0]    dbgRegData,
  output logic [31:0]        instr,
  output logic               aluZero,
  output logic               pcSel,
  output logic [XLEN-1:0]    pc
);

  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] rdA, rdB, immExt, aluB, aluY, memRd, wbData;
  logic [XLEN-1:0] pcPlus4, brTarget, pcNext;
  logic [4:0]      wAddr;

  // instruction fetch and preload of the instruction store
  assign instr = imem[pc[IAW+1:2]];

  always_ff @(posedge clk) begin
    if (loadEn && !loadSel) imem[loadAddr[IAW-1:0]] <= loadData[31:0];
  end

  sc_regfile #(.XLEN(XLEN), .NREGS(32)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (ctrl.regWrite),
    .wAddr    (wAddr),
    .wData    (wbData),
    .rAddrA   (instr[25:21]),
    .rAddrB   (instr[20:16]),
    .rAddrDbg (dbgRegSel),
    .rDataA   (rdA),
    .rDataB   (rdB),
    .rDataDbg (dbgRegData)
  );

  assign immExt = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign aluB   = ctrl.useImm ? immExt : rdB;
  assign wAddr  = ctrl.destRd ? instr[15:11] : instr[20:16];

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a    (rdA),
    .b    (aluB),
    .op   (ctrl.aluOp),
    .y    (aluY),
    .zero (aluZero)
  );

  // data store: a program store has priority over a preload in the same cycle
  always_ff @(posedge clk) begin
    if (ctrl.memWrite)           dmem[aluY[DAW+1:2]]      <= rdB;
    else if (loadEn && loadSel)  dmem[loadAddr[DAW-1:0]]  <= loadData;
  end

  assign memRd  = ctrl.memRead ? dmem[aluY[DAW+1:2]] : '0;
  assign wbData = ctrl.wbFromMem ? memRd : aluY;

  // next program counter
  assign pcPlus4  = pc + XLEN'(4);
  assign brTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign pcSel    = ctrl.isBranch && aluZero;
  assign pcNext   = pcSel ? brTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic               loadSel,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  input  logic [4:0]         dbgRegSel,
  output logic [31:0]        dbgRegData,
  output logic [31:0]        pcOut
);

  ctrl_t       ctrl;
  logic [31:0] instr;
  logic        aluZero;
  logic        pcSel;

  sc_control u_ctrl (
    .rst   (rst),
    .instr (instr),
    .ctrl  (ctrl)
  );

  sc_datapath #(
    .XLEN       (32),
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS),
    .LOAD_AW    (LOAD_AW)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .loadEn     (loadEn),
    .loadSel    (loadSel),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .dbgRegSel  (dbgRegSel),
    .dbgRegData (dbgRegData),
    .instr      (instr),
    .aluZero    (aluZero),
    .pcSel      (pcSel),
    .pc         (pcOut)
  );

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic [31:0] instr,
  input ctrl_t       ctrl,
  input logic        pcSel
);

  logic knownOp;
  assign knownOp = (instr[31:26] == OP_REG)   || (instr[31:26] == OP_LOAD) ||
                   (instr[31:26] == OP_STORE) || (instr[31:26] == OP_BEQ);

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pcOut == 32'd0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |-> (!ctrl.regWrite && !ctrl.memWrite));

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !pcSel |=> (pcOut == $past(pcOut) + 32'd4));

  // R6
  br_target_chk: assert property (@(posedge clk) disable iff (rst)
    pcSel |=> (pcOut == $past(pcOut) + 32'd4 +
               {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  // R6
  br_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.isBranch |-> (!ctrl.regWrite && !ctrl.memWrite));

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !ctrl.regWrite);

  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> (!ctrl.regWrite && !ctrl.memWrite && !pcSel));

endmodule

bind sc_core sc_core_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .pcOut (pcOut),
  .instr (instr),
  .ctrl  (ctrl),
  .pcSel (pcSel)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadSel = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  dbgRegSel = '0;
  logic [31:0] dbgRegData;
  logic [31:0] pcOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;   // 125 MHz

  sc_core dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadSel(loadSel),
    .loadAddr(loadAddr), .loadData(loadData), .dbgRegSel(dbgRegSel),
    .dbgRegData(dbgRegData), .pcOut(pcOut)
  );

  // behavioural reference state
  logic [31:0] mImem [64];
  logic [31:0] mDmem [64];
  logic [31:0] mRegs [32];
  logic [31:0] mPc;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rIns(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] iIns(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic loadWord(input bit sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadAddr = 8'(addr); loadData = data;
    if (sel) mDmem[addr] = data; else mImem[addr] = data;
  endtask

  task automatic readReg(input int r, output logic [31:0] v);
    dbgRegSel = 5'(r);
    #0.5;
    v = dbgRegData;
  endtask

  // one instruction of the reference model
  task automatic modelStep();
    logic [31:0] ins, a, b, se, res, addr;
    logic        wr;
    int          dst;
    ins = mImem[mPc[7:2]];
    a   = (ins[25:21] == 0) ? 32'd0 : mRegs[ins[25:21]];
    b   = (ins[20:16] == 0) ? 32'd0 : mRegs[ins[20:16]];
    se  = {{16{ins[15]}}, ins[15:0]};
    wr  = 0; dst = 0; res = 0;
    mPc = mPc + 4;
    case (ins[31:26])
      6'h00: begin
        dst = int'(ins[15:11]); wr = 1;
        case (ins[5:0])
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: wr = 0;
        endcase
      end
      6'h23: begin addr = a + se; res = mDmem[addr[7:2]]; dst = int'(ins[20:16]); wr = 1; end
      6'h2B: begin addr = a + se; mDmem[addr[7:2]] = b; end
      6'h04: if (a == b) mPc = mPc + (se << 2);
      default: ;
    endcase
    if (wr && dst != 0) mRegs[dst] = res;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 32; i++) mRegs[i] = '0;
    mPc = '0;

    // R10: fill both stores during reset
    for (int i = 0; i < 64; i++) loadWord(1'b0, i, 32'hFC00_0000);
    for (int i = 0; i < 64; i++) loadWord(1'b1, i, 32'hA500_0000 + 32'(i) * 32'h0101_0101);
    loadWord(1, 0, 32'd5);
    loadWord(1, 1, 32'hFFFF_FFFD);
    loadWord(1, 2, 32'h0F0F_00FF);
    loadWord(1, 3, 32'h00FF_0F0F);
    loadWord(1, 5, 32'd28);
    loadWord(1, 6, 32'h1234_5678);

    loadWord(0, 0,  iIns(6'h23, 0, 1, 0));
    loadWord(0, 1,  iIns(6'h23, 0, 2, 4));
    loadWord(0, 2,  iIns(6'h23, 0, 3, 8));
    loadWord(0, 3,  iIns(6'h23, 0, 4, 12));
    loadWord(0, 4,  rIns(1, 2, 5, 6'h20));
    loadWord(0, 5,  rIns(1, 2, 6, 6'h22));
    loadWord(0, 6,  rIns(3, 4, 7, 6'h24));
    loadWord(0, 7,  rIns(3, 4, 8, 6'h25));
    loadWord(0, 8,  rIns(2, 1, 9, 6'h2A));
    loadWord(0, 9,  rIns(1, 2, 10, 6'h2A));
    loadWord(0, 10, rIns(1, 1, 0, 6'h20));
    loadWord(0, 11, iIns(6'h2B, 0, 5, 16));
    loadWord(0, 12, iIns(6'h23, 0, 11, 16));
    loadWord(0, 13, iIns(6'h23, 0, 13, 20));
    loadWord(0, 14, iIns(6'h23, 13, 12, -4));
    loadWord(0, 15, iIns(6'h0F, 0, 1, 16'h1234));
    loadWord(0, 16, rIns(1, 2, 1, 6'h27));
    loadWord(0, 17, iIns(6'h04, 1, 2, 5));
    loadWord(0, 18, iIns(6'h04, 5, 11, 2));
    loadWord(0, 19, rIns(1, 1, 14, 6'h20));
    loadWord(0, 20, rIns(1, 1, 15, 6'h20));
    loadWord(0, 21, rIns(1, 1, 16, 6'h20));
    loadWord(0, 22, iIns(6'h04, 0, 0, -1));

    @(negedge clk);
    loadEn = 1'b0;
    @(negedge clk);
    #0.5;
    check(pcOut == 0, "R1 pc in reset", pcOut, 0);
    readReg(7, v);
    check(v == 0, "R1 reg cleared in reset", v, 0);

    @(negedge clk);
    rst = 1'b0;

    for (int cyc = 0; cyc < 40; cyc++) begin
      readReg(cyc % 32, v);
      check(pcOut == mPc, "R7 pc tracks model", pcOut, mPc);
      check(v == mRegs[cyc % 32], "R11 register tracks model", v, mRegs[cyc % 32]);
      modelStep();
      @(negedge clk);
    end

    // directed final values, computed by hand
    readReg(1, v);  check(v == 32'd5,         "R4 load r1 (R9 unknown ops left it)", v, 32'd5);
    readReg(2, v);  check(v == 32'hFFFF_FFFD, "R4 load r2", v, 32'hFFFF_FFFD);
    readReg(5, v);  check(v == 32'd2,         "R2 add", v, 32'd2);
    readReg(6, v);  check(v == 32'd8,         "R2 sub", v, 32'd8);
    readReg(7, v);  check(v == 32'h000F_000F, "R2 and", v, 32'h000F_000F);
    readReg(8, v);  check(v == 32'h0FFF_0FFF, "R2 or", v, 32'h0FFF_0FFF);
    readReg(9, v);  check(v == 32'd1,         "R3 slt negative<positive", v, 32'd1);
    readReg(10, v); check(v == 32'd0,         "R3 slt positive<negative", v, 32'd0);
    readReg(0, v);  check(v == 32'd0,         "R8 write to reg0 ignored", v, 32'd0);
    readReg(11, v); check(v == 32'd2,         "R5 store then load", v, 32'd2);
    readReg(12, v); check(v == 32'h1234_5678, "R4 negative offset", v, 32'h1234_5678);
    readReg(14, v); check(v == 32'd0,         "R6 skipped by taken branch", v, 32'd0);
    readReg(15, v); check(v == 32'd0,         "R6 skipped by taken branch", v, 32'd0);
    readReg(16, v); check(v == 32'd10,        "R6 branch target executed", v, 32'd10);
    check(pcOut == 32'd88, "R6 backward branch holds pc", pcOut, 32'd88);
    readReg(3, v);  check(v == 32'h0F0F_00FF, "R10 preloaded data word", v, 32'h0F0F_00FF);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule